// File: doc/BRIEF.md
# Audio Codec Mixer Register Bank

This block holds the 16-bit mixer and control registers of an audio codec and exposes them through a single 32-bit command word. The host writes one command per cycle on `cmd_wdata` with `cmd_we` high. A command either updates one codec register, following that register's own write rule, or fetches a register value. In both cases the command word is captured into `cmd_rdata`, and the host reads it back from there. A read result carries a data-valid flag and the fetched value in the low half.

Some writes have side effects. A write to the reset register restores every default. The master volume register saturates a channel field when its overflow bit is set. Some entries are read-only or only partly writable. The two sample-rate registers accept values only while variable-rate mode is on, and they snap each value to one of seven supported rates. A two-state machine tracks the variable-rate mode. The current output (DAC) rate is presented on `dac_rate`, and `rate_pulse` marks each change of it.

Top module: `codec_regbank`

States and transitions of the rate-mode machine:
- `VR_FIXED`: rate registers are locked. This is the reset state.
- `VR_VARIABLE`: rate registers accept snapped writes.
- Enable transition: `VR_FIXED` to `VR_VARIABLE` on a write to the extended control register (byte address 0x2A) with bit 0 set.
- Disable transition: `VR_VARIABLE` to `VR_FIXED` on a write to that register with bit 0 clear.
- Restore transition: `VR_VARIABLE` to `VR_FIXED` on any write to the reset register.

## Requirements
- R1: After reset, reads return these values. Byte address 0x00 reads 0x6A90, 0x02 reads 0x8000, 0x10 and 0x18 read 0x8808, 0x26 reads 0x000F, 0x28 reads 0x0A05, 0x2A reads 0x0400, 0x2C and 0x32 read 48000 (0xBB80), 0x7C reads 0x8384 and 0x7E reads 0x7666. Every other register reads 0. Also `cmd_rdata` is 0, `rate_pulse` is 0 and `dac_rate` is 48000.
- R2: Command fields are: bits 31:30 codec select, bit 23 read flag, bits 22:16 address, bits 15:0 data. A command whose select is nonzero is ignored. No register changes, and `cmd_rdata` keeps its previous value.
- R3: One cycle after an accepted command, `cmd_rdata` holds a result. For a read it is bits 31:30 and 23:16 of the command, with bit 25 set, the register value in bits 15:0, and all other bits zero. For a write it is the command ANDed with 0xC0FFFFFF.
- R4: A write of any data to the reset register (byte address 0x00) restores every register to its R1 value and returns the machine to `VR_FIXED`.
- R5: A master volume write (0x02) works as follows. Data bit 13 forces bits 12:8 to ones. Data bit 5 forces bits 4:0 to ones. The result is then stored ANDed with 0x9F1F.
- R6: A PCM-out volume write (0x18) stores the data ANDed with 0x9F1F, with no forcing.
- R7: A powerdown write (0x26) replaces only the upper byte. The lower byte keeps its value.
- R8: Writes to the extended ID register (0x28) and to the two vendor ID registers (0x7C, 0x7E) are ignored.
- R9: The extended control register (0x2A) reads as 0x0400 with bit 0 equal to the variable-rate enable, which is the only writable bit. Writing bit 0 as 0 sets both rate registers (0x2C, 0x32) to 48000.
- R10: While variable rate is disabled, writes to the rate registers are ignored.
- R11: While variable rate is enabled, a rate write stores the first rate of 8000, 11025, 16000, 22050, 32000 and 44100 whose midpoint to the next rate (integer half of the gap) is greater than the data. Data at or above 46050 stores 48000.
- R12: The register index is the address with bit 0 dropped, so odd and even addresses reach the same register. Any register without a rule above stores the full 16-bit data.
- R13: `dac_rate` equals the register at 0x2C. `rate_pulse` is high for exactly the cycle after a write that changed that value, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command word valid this cycle |
| cmd_wdata | input | 32 | Command word |
| cmd_rdata | output | 32 | Captured command or read result |
| rate_pulse | output | 1 | One-cycle marker of an output-rate change |
| dac_rate | output | 16 | Current output sample rate |

## Verification
Every register write and the mode state become visible on the next cycle. A wrong stored value therefore shows in the next read of that address. A wrong mode state shows on the following rate write: a locked register changes, or an enabled register does not. A lost or spurious rate change shows the same cycle on `rate_pulse` against `dac_rate`. The sweeps cover snapping boundaries on both sides of each midpoint, and every third master volume pattern.

// File: rtl/codec_regbank_pkg.sv
package codec_regbank_pkg;
    localparam int CMD_W     = 32;
    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 16;
    localparam int IDX_W     = ADDR_W - 1;
    localparam int NUM_REGS  = 1 << IDX_W;
    localparam int NUM_RATES = 7;
    localparam int SEL_HI    = 31;
    localparam int SEL_LO    = 30;
    localparam int RD_BIT    = 23;
    localparam int VALID_BIT = 25;

    localparam logic [IDX_W-1:0] I_RESET   = 6'h00;
    localparam logic [IDX_W-1:0] I_MASTER  = 6'h01;
    localparam logic [IDX_W-1:0] I_LINEIN  = 6'h08;
    localparam logic [IDX_W-1:0] I_PCM     = 6'h0C;
    localparam logic [IDX_W-1:0] I_PWR     = 6'h13;
    localparam logic [IDX_W-1:0] I_EXT_ID  = 6'h14;
    localparam logic [IDX_W-1:0] I_EXT_CTL = 6'h15;
    localparam logic [IDX_W-1:0] I_DAC     = 6'h16;
    localparam logic [IDX_W-1:0] I_ADC     = 6'h19;
    localparam logic [IDX_W-1:0] I_VEND_HI = 6'h3E;
    localparam logic [IDX_W-1:0] I_VEND_LO = 6'h3F;

    localparam logic [DATA_W-1:0] RATE_MAX    = 16'd48000;
    localparam logic [DATA_W-1:0] EXT_CTL_VAL = 16'h0400;
    localparam logic [DATA_W-1:0] VOL_MASK    = 16'h9F1F;
    localparam logic [CMD_W-1:0]  WR_KEEP     = 32'hC0FF_FFFF;

    typedef enum logic {VR_FIXED, VR_VARIABLE} vr_state_e;

    typedef struct packed {
        logic              sel_ok;
        logic              is_read;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } codec_cmd_t;

    function automatic int rate_at(input int i);
        case (i)
            0:       return 8000;
            1:       return 11025;
            2:       return 16000;
            3:       return 22050;
            4:       return 32000;
            5:       return 44100;
            default: return 48000;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] default_of(input logic [IDX_W-1:0] idx);
        case (idx)
            I_RESET:          return 16'h6A90;
            I_MASTER:         return 16'h8000;
            I_LINEIN, I_PCM:  return 16'h8808;
            I_PWR:            return 16'h000F;
            I_EXT_ID:         return 16'h0A05;
            I_EXT_CTL:        return EXT_CTL_VAL;
            I_DAC, I_ADC:     return RATE_MAX;
            I_VEND_HI:        return 16'h8384;
            I_VEND_LO:        return 16'h7666;
            default:          return '0;
        endcase
    endfunction
endpackage

// File: rtl/codec_cmd_decode.sv
module codec_cmd_decode
    import codec_regbank_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_word,
    output codec_cmd_t       cmd
);
    assign cmd.sel_ok  = (cmd_word[SEL_HI:SEL_LO] == '0);
    assign cmd.is_read = cmd_word[RD_BIT];
    assign cmd.idx     = cmd_word[16 + ADDR_W - 1 : 17];
    assign cmd.data    = cmd_word[DATA_W-1:0];
endmodule

// File: rtl/codec_rate_snap.sv
module codec_rate_snap
    import codec_regbank_pkg::*;
(
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] snapped
);
    logic [NUM_RATES-2:0] below;

    for (genvar i = 0; i < NUM_RATES - 1; i++) begin : g_thr
        localparam int THR = rate_at(i) + (rate_at(i + 1) - rate_at(i)) / 2;
        assign below[i] = (int'(raw) < THR);
    end

    always_comb begin
        snapped = RATE_MAX;
        for (int i = NUM_RATES - 2; i >= 0; i--) begin
            if (below[i]) snapped = DATA_W'(rate_at(i));
        end
    end
endmodule

// File: rtl/codec_write_rules.sv
module codec_write_rules
    import codec_regbank_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] old_val,
    output logic              store_en,
    output logic [DATA_W-1:0] store_val
);
    logic [DATA_W-1:0] sat;

    always_comb begin
        sat = wdata;
        if (wdata[13]) sat[12:8] = '1;
        if (wdata[5])  sat[4:0]  = '1;
    end

    always_comb begin
        store_en  = 1'b1;
        store_val = wdata;
        unique case (idx)
            I_MASTER: store_val = sat & VOL_MASK;
            I_PCM:    store_val = wdata & VOL_MASK;
            I_PWR:    store_val = {wdata[15:8], old_val[7:0]};
            I_RESET, I_EXT_ID, I_EXT_CTL, I_DAC, I_ADC, I_VEND_HI, I_VEND_LO:
                      store_en = 1'b0;
            default:  store_val = wdata;
        endcase
    end
endmodule

// File: rtl/codec_regbank.sv
module codec_regbank
    import codec_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    output logic [CMD_W-1:0]  cmd_rdata,
    output logic              rate_pulse,
    output logic [DATA_W-1:0] dac_rate
);
    codec_cmd_t        cmd;
    vr_state_e         vr_q, vr_d;
    logic [DATA_W-1:0] regs_q [NUM_REGS];
    logic [DATA_W-1:0] snapped, store_val, rd_val, ext_ctl_rd, dac_next;
    logic              store_en, go, wr_go, vr_is_var;
    logic [CMD_W-1:0]  rdata_q;
    logic              pulse_q;

    codec_cmd_decode u_dec (.cmd_word(cmd_wdata), .cmd(cmd));
    codec_rate_snap  u_snap (.raw(cmd.data), .snapped(snapped));
    codec_write_rules u_rules (
        .idx(cmd.idx), .wdata(cmd.data), .old_val(regs_q[cmd.idx]),
        .store_en(store_en), .store_val(store_val)
    );

    assign go    = cmd_we && cmd.sel_ok;
    assign wr_go = go && !cmd.is_read;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) vr_q <= VR_FIXED;
        else        vr_q <= vr_d;
    end

    // next state
    always_comb begin
        vr_d = vr_q;
        unique case (vr_q)
            VR_FIXED:
                if (wr_go && cmd.idx == I_EXT_CTL && cmd.data[0]) vr_d = VR_VARIABLE;
            VR_VARIABLE:
                if (wr_go && ((cmd.idx == I_EXT_CTL && !cmd.data[0]) || cmd.idx == I_RESET))
                    vr_d = VR_FIXED;
            default: vr_d = VR_FIXED;
        endcase
    end

    // outputs of the state
    always_comb begin
        vr_is_var  = (vr_q == VR_VARIABLE);
        ext_ctl_rd = EXT_CTL_VAL | {{(DATA_W-1){1'b0}}, vr_is_var};
    end

    assign rd_val = (cmd.idx == I_EXT_CTL) ? ext_ctl_rd : regs_q[cmd.idx];

    always_comb begin
        dac_next = regs_q[I_DAC];
        if (wr_go) begin
            if (cmd.idx == I_RESET) dac_next = RATE_MAX;
            else if (cmd.idx == I_EXT_CTL && !cmd.data[0]) dac_next = RATE_MAX;
            else if (cmd.idx == I_DAC && vr_is_var) dac_next = snapped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= default_of(IDX_W'(i));
        end else if (wr_go) begin
            if (cmd.idx == I_RESET) begin
                for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= default_of(IDX_W'(i));
            end else if (cmd.idx == I_EXT_CTL) begin
                if (!cmd.data[0]) begin
                    regs_q[I_DAC] <= RATE_MAX;
                    regs_q[I_ADC] <= RATE_MAX;
                end
            end else if (cmd.idx == I_DAC || cmd.idx == I_ADC) begin
                if (vr_is_var) regs_q[cmd.idx] <= snapped;
            end else if (store_en) begin
                regs_q[cmd.idx] <= store_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= wr_go && (dac_next != regs_q[I_DAC]);
            if (go) begin
                if (cmd.is_read)
                    rdata_q <= {cmd_wdata[SEL_HI:SEL_LO], 4'b0000, 1'b1, 1'b0,
                                cmd_wdata[23:16], rd_val};
                else
                    rdata_q <= cmd_wdata & WR_KEEP;
            end
        end
    end

    assign cmd_rdata  = rdata_q;
    assign rate_pulse = pulse_q;
    assign dac_rate   = regs_q[I_DAC];
endmodule

// File: rtl/codec_regbank_chk.sv
module codec_regbank_chk
    import codec_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_we,
    input logic [CMD_W-1:0]  cmd_wdata,
    input logic [CMD_W-1:0]  cmd_rdata,
    input logic              rate_pulse,
    input logic [DATA_W-1:0] dac_rate,
    input logic              vr_variable
);
    // R2: select nonzero leaves the result register alone
    p_sel_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[31:30] != 2'b00) |=> $stable(cmd_rdata));

    // R3: read result carries the valid flag and the read flag
    p_read_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[31:30] == 2'b00 && cmd_wdata[23])
        |=> (cmd_rdata[25] && cmd_rdata[23] && cmd_rdata[29:26] == 4'h0 && !cmd_rdata[24]));

    // R3: write result clears bits 29:24
    p_write_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[31:30] == 2'b00 && !cmd_wdata[23])
        |=> (cmd_rdata[29:24] == 6'h00));

    // R9, R10: locked mode keeps the output rate at its maximum
    p_fixed_rate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vr_variable |-> (dac_rate == 16'd48000));

    // R11: output rate is always one of the supported rates
    p_rate_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_rate == 16'd8000  || dac_rate == 16'd11025 || dac_rate == 16'd16000 ||
         dac_rate == 16'd22050 || dac_rate == 16'd32000 || dac_rate == 16'd44100 ||
         dac_rate == 16'd48000));

    // R13: a pulse means the rate moved, and a command caused it
    p_pulse_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rate_pulse |-> (dac_rate != $past(dac_rate) && $past(cmd_we)));

    // R13: no pulse means no movement
    p_pulse_needed_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_pulse |-> $stable(dac_rate));
endmodule

bind codec_regbank codec_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .rate_pulse(rate_pulse), .dac_rate(dac_rate),
    .vr_variable(vr_is_var)
);

// File: tb/test_codec_regbank.sv
module test_codec_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        rate_pulse;
    logic [15:0] dac_rate;

    int n_checks = 0;
    int n_errors = 0;
    logic last_pulse;

    always #10 clk = ~clk;

    codec_regbank i_codec_regbank (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .rate_pulse(rate_pulse), .dac_rate(dac_rate)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
        last_pulse = rate_pulse;
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        send({8'h00, 1'b0, a, d});
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] v);
        send({8'h00, 1'b1, a, 16'h0000});
        chk("R3 read header", {16'h0, cmd_rdata[31:16]}, {16'h0, 16'h0280 | {9'h0, a}});
        v = cmd_rdata[15:0];
    endtask

    function automatic logic [15:0] dflt(input logic [6:0] a);
        case (a & 7'h7E)
            7'h00: return 16'h6A90;
            7'h02: return 16'h8000;
            7'h10: return 16'h8808;
            7'h18: return 16'h8808;
            7'h26: return 16'h000F;
            7'h28: return 16'h0A05;
            7'h2A: return 16'h0400;
            7'h2C: return 16'd48000;
            7'h32: return 16'd48000;
            7'h7C: return 16'h8384;
            7'h7E: return 16'h7666;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] snap_model(input int v);
        int r [7] = '{8000, 11025, 16000, 22050, 32000, 44100, 48000};
        for (int i = 0; i < 6; i++) begin
            if (v < r[i] + (r[i+1] - r[i]) / 2) return 16'(r[i]);
        end
        return 16'd48000;
    endfunction

    function automatic bit is_special(input logic [6:0] a);
        case (a)
            7'h00, 7'h02, 7'h18, 7'h26, 7'h28, 7'h2A, 7'h2C, 7'h32, 7'h7C, 7'h7E: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_defaults(input string tag);
        logic [15:0] v;
        for (int a = 0; a < 128; a += 2) begin
            rd(7'(a), v);
            chk(tag, {16'h0, v}, {16'h0, dflt(7'(a))});
        end
    endtask

    initial begin
        #(200000 * 20);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] v, exp, prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata after reset", cmd_rdata, 32'h0);
        chk("R1 pulse after reset", {31'h0, rate_pulse}, 32'h0);
        chk("R1 dac_rate after reset", {16'h0, dac_rate}, 32'd48000);
        check_defaults("R1 default");

        // R3 result formats
        send(32'h3F04_1234);
        chk("R3 write result", cmd_rdata, 32'h0004_1234);
        send(32'h1D84_FFFF);
        chk("R3 read result", cmd_rdata, 32'h0284_1234);

        // R2 nonzero select ignored
        send(32'h4004_BEEF);
        chk("R2 write ignored rdata", cmd_rdata, 32'h0284_1234);
        send(32'h8084_0000);
        chk("R2 read ignored rdata", cmd_rdata, 32'h0284_1234);
        rd(7'h04, v);
        chk("R2 register unchanged", {16'h0, v}, 32'h1234);

        // R12 plain registers and odd addresses
        for (int a = 0; a < 128; a += 2) begin
            if (!is_special(7'(a))) wr(7'(a + 1), 16'hC3A0 ^ 16'(a * 257));
        end
        for (int a = 0; a < 128; a += 2) begin
            if (!is_special(7'(a))) begin
                rd(7'(a), v);
                chk("R12 plain store", {16'h0, v}, {16'h0, 16'hC3A0 ^ 16'(a * 257)});
            end
        end

        // R5 master volume sweep
        for (int d = 0; d < 65536; d += 3) begin
            exp = 16'(d);
            if (exp[13]) exp[12:8] = 5'h1F;
            if (exp[5])  exp[4:0]  = 5'h1F;
            exp &= 16'h9F1F;
            wr(7'h02, 16'(d));
            rd(7'h02, v);
            chk("R5 master", {16'h0, v}, {16'h0, exp});
        end

        // R6 pcm out
        wr(7'h18, 16'hFFFF); rd(7'h18, v);
        chk("R6 pcm ones", {16'h0, v}, 32'h9F1F);
        wr(7'h18, 16'h2020); rd(7'h18, v);
        chk("R6 pcm no forcing", {16'h0, v}, 32'h0000);

        // R7 powerdown
        wr(7'h26, 16'hABCD); rd(7'h26, v);
        chk("R7 powerdown upper", {16'h0, v}, 32'hAB0F);
        wr(7'h26, 16'h12FF); rd(7'h26, v);
        chk("R7 powerdown lower kept", {16'h0, v}, 32'h120F);

        // R8 read-only
        wr(7'h28, 16'h0000); wr(7'h7C, 16'h1111); wr(7'h7E, 16'h2222);
        rd(7'h28, v); chk("R8 ext id", {16'h0, v}, 32'h0A05);
        rd(7'h7C, v); chk("R8 vendor hi", {16'h0, v}, 32'h8384);
        rd(7'h7E, v); chk("R8 vendor lo", {16'h0, v}, 32'h7666);

        // R10 rate writes locked
        wr(7'h2C, 16'd8000);
        chk("R10 locked pulse", {31'h0, last_pulse}, 32'h0);
        rd(7'h2C, v); chk("R10 dac locked", {16'h0, v}, 32'd48000);
        wr(7'h32, 16'd8000);
        rd(7'h32, v); chk("R10 adc locked", {16'h0, v}, 32'd48000);

        // R9 enable bit
        wr(7'h2A, 16'hFFFF);
        rd(7'h2A, v); chk("R9 enable readback", {16'h0, v}, 32'h0401);

        // R11 / R13 snapping sweep
        prev = 16'd48000;
        for (int d = 0; d < 65536 + 13 * 7; d += 13) begin
            int dv;
            dv = (d < 65536) ? d : (d - 65536) * 0;
            if (d >= 65536) begin
                case ((d - 65536) / 13)
                    0: dv = 9511;  1: dv = 9512;  2: dv = 13511; 3: dv = 19025;
                    4: dv = 27024; 5: dv = 38050; default: dv = 46049;
                endcase
            end
            exp = snap_model(dv);
            wr(7'h2C, 16'(dv));
            chk("R13 pulse on change", {31'h0, last_pulse}, {31'h0, exp != prev});
            chk("R13 dac_rate port", {16'h0, dac_rate}, {16'h0, exp});
            rd(7'h2D, v);
            chk("R11 dac snap", {16'h0, v}, {16'h0, exp});
            prev = exp;
        end
        wr(7'h32, 16'd20000); rd(7'h32, v);
        chk("R11 adc snap", {16'h0, v}, 32'd22050);
        wr(7'h32, 16'd46050); rd(7'h32, v);
        chk("R11 adc cap", {16'h0, v}, 32'd48000);

        // R9 clearing forces both rates
        wr(7'h2C, 16'd8000); wr(7'h32, 16'd11025);
        wr(7'h2A, 16'hFFFE);
        chk("R9 clear pulse", {31'h0, last_pulse}, 32'h1);
        rd(7'h2A, v); chk("R9 disable readback", {16'h0, v}, 32'h0400);
        rd(7'h2C, v); chk("R9 dac forced", {16'h0, v}, 32'd48000);
        rd(7'h32, v); chk("R9 adc forced", {16'h0, v}, 32'd48000);

        // R4 reset register
        wr(7'h2A, 16'h0001); wr(7'h2C, 16'd16000); wr(7'h04, 16'h5555);
        wr(7'h02, 16'h0000); wr(7'h26, 16'h7700);
        wr(7'h00, 16'h1357);
        chk("R4 reset pulse", {31'h0, last_pulse}, 32'h1);
        chk("R4 reset dac_rate", {16'h0, dac_rate}, 32'd48000);
        check_defaults("R4 restored");
        wr(7'h2C, 16'd8000);
        rd(7'h2C, v); chk("R4 back to fixed mode", {16'h0, v}, 32'd48000);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule